// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by reading a two-level page table that lives in untranslated physical memory. A miss request carries a 20-bit virtual page number. The upper ten bits of that number select an entry in the first-level table, whose physical base comes from a root register. The lower ten bits select an entry in the second-level table that the first entry points to. The 12-bit page offset never reaches the walker.

Each entry fetched is sorted into one of three kinds: a usable link or mapping, a page that exists but is held in secondary storage, or a page that does not exist. A usable second-level mapping produces a one-cycle refill pulse with the physical page number and four permission bits. Either of the other two kinds, at either level, ends the walk with a one-cycle fault pulse against the original request. The memory side is a simple read port with one read outstanding at a time. The walker handles one miss at a time and ignores new requests while it is busy.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `mem_rd_req`, `refill_valid` and `fault_valid` are 0.
- R2: The first read is issued in the cycle after a request is accepted, at address root + 4 × vpn[19:10]. The root is the value of `root_base` in the accepting cycle, and later changes do not affect that walk.
- R3: An entry is a usable link or mapping when bit 0 (valid) and bit 1 (resident) are both 1. A usable first-level entry leads to a second read at address (entry[31:12] << 12) + 4 × vpn[9:0].
- R4: A usable second-level entry produces `refill_valid` with `refill_ppn` = entry[31:12]. `refill_perm` is entry[5:2], where perm bit 0 is read, bit 1 is write, bit 2 is user and bit 3 is dirty. `resp_vpn` echoes the request.
- R5: An entry with valid = 1 and resident = 0 ends the walk with `fault_valid` and `fault_absent` = 1, and no further read is made.
- R6: An entry with valid = 0 ends the walk with `fault_valid` and `fault_absent` = 0, whatever its other bits are, and no further read is made.
- R7: `fault_level` is 0 when the first-level entry caused the fault and 1 when the second-level entry caused it. `resp_vpn` echoes the faulting request.
- R8: `refill_valid` and `fault_valid` each stay high for exactly one cycle, and they are never high together.
- R9: `req_ready` is low from the cycle after acceptance until the response cycle ends. A request made while the walker is busy is ignored. At most one memory read is outstanding, and no read is issued while `req_ready` is high.
- R10: A request that is still held during the response cycle is not taken in that cycle. It is accepted in the idle cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Physical base address of the current first-level table |
| req_valid | input | 1 | Miss request present |
| req_vpn | input | 20 | Virtual page number to translate |
| req_ready | output | 1 | Walker idle; a request is taken this cycle |
| mem_rd_req | output | 1 | One-cycle read request to physical memory |
| mem_rd_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| refill_valid | output | 1 | One-cycle pulse: translation found |
| resp_vpn | output | 20 | Virtual page number of the finished walk |
| refill_ppn | output | 20 | Physical page number for the refill |
| refill_perm | output | 4 | Permissions {dirty, user, write, read} |
| fault_valid | output | 1 | One-cycle pulse: walk aborted with a page fault |
| fault_level | output | 1 | Level whose entry caused the fault (0 first, 1 second) |
| fault_absent | output | 1 | 1 = page not resident, 0 = page nonexistent |

## Verification
The two functions that can meet in one cycle are the delivery of a walk's response and the arrival of the next miss request. The bench holds a second request high from just after the first is accepted, through the whole walk and into the response pulse. The response must still carry the first walk's results, and no extra memory read may appear during that walk. The held request must be taken only in the idle cycle after the pulse, and its own walk must read the addresses and return the mapping for the second page number.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // Entry bit positions that the walker decodes
  localparam int ENT_VALID_BIT    = 0;
  localparam int ENT_RESIDENT_BIT = 1;
  localparam int ENT_PERM_LSB     = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_L1,
    ST_WAIT_L1,
    ST_READ_L2,
    ST_WAIT_L2,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] table_base,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] entry_addr
);

  // An entry is four bytes, so the index is scaled by four
  function automatic logic [ADDR_W-1:0] scaled_entry(
    input logic [ADDR_W-1:0] base,
    input logic [IDX_W-1:0]  idx
  );
    logic [ADDR_W-1:0] off;
    off = ADDR_W'(idx) << 2;
    return base + off;
  endfunction

  assign entry_addr = scaled_entry(table_base, index);

endmodule

// File: rtl/ptw_entry_class.sv
module ptw_entry_class
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 12,
  parameter int PERM_W = 4
) (
  input  logic [ADDR_W-1:0]        entry,
  output logic                     is_link,
  output logic                     is_absent,
  output logic                     is_void,
  output logic [ADDR_W-OFFS_W-1:0] frame,
  output logic [PERM_W-1:0]        perm
);

  assign is_link   = entry[ENT_VALID_BIT] & entry[ENT_RESIDENT_BIT];
  assign is_absent = entry[ENT_VALID_BIT] & ~entry[ENT_RESIDENT_BIT];
  assign is_void   = ~entry[ENT_VALID_BIT];
  assign frame     = entry[ADDR_W-1:OFFS_W];
  assign perm      = entry[ENT_PERM_LSB +: PERM_W];

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int L1_IDX_W = 10,
  parameter int L2_IDX_W = 10,
  parameter int OFFS_W   = 12,
  parameter int PERM_W   = 4,
  localparam int VPN_W   = L1_IDX_W + L2_IDX_W,
  localparam int PPN_W   = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              req_ready,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              refill_valid,
  output logic [VPN_W-1:0]  resp_vpn,
  output logic [PPN_W-1:0]  refill_ppn,
  output logic [PERM_W-1:0] refill_perm,
  output logic              fault_valid,
  output logic              fault_level,
  output logic              fault_absent
);

  localparam int LEVELS = 2;
  localparam int IDX_MAX = (L1_IDX_W > L2_IDX_W) ? L1_IDX_W : L2_IDX_W;

  walk_state_t state_q, state_d;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] root_q;
  logic [PPN_W-1:0]  table_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [PERM_W-1:0] perm_q;
  logic              flt_level_q;
  logic              flt_absent_q;

  // Named events for the checker
  logic accept;
  logic take_l1;
  logic take_l2;
  logic lvl1_link_take;
  logic walk_abort;

  logic              ent_link, ent_absent, ent_void;
  logic [PPN_W-1:0]  ent_frame;
  logic [PERM_W-1:0] ent_perm;

  logic [ADDR_W-1:0]  lvl_base [LEVELS];
  logic [IDX_MAX-1:0] lvl_idx  [LEVELS];
  logic [ADDR_W-1:0]  lvl_addr [LEVELS];

  assign lvl_base[0] = root_q;
  assign lvl_idx[0]  = IDX_MAX'(vpn_q[VPN_W-1 -: L1_IDX_W]);
  assign lvl_base[1] = {table_q, {OFFS_W{1'b0}}};
  assign lvl_idx[1]  = IDX_MAX'(vpn_q[L2_IDX_W-1:0]);

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    ptw_addr_gen #(
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_MAX)
    ) u_addr (
      .table_base(lvl_base[lv]),
      .index     (lvl_idx[lv]),
      .entry_addr(lvl_addr[lv])
    );
  end

  ptw_entry_class #(
    .ADDR_W(ADDR_W),
    .OFFS_W(OFFS_W),
    .PERM_W(PERM_W)
  ) u_class (
    .entry    (mem_rsp_data),
    .is_link  (ent_link),
    .is_absent(ent_absent),
    .is_void  (ent_void),
    .frame    (ent_frame),
    .perm     (ent_perm)
  );

  assign req_ready      = (state_q == ST_IDLE);
  assign accept         = req_valid && req_ready;
  assign take_l1        = mem_rsp_valid && (state_q == ST_WAIT_L1);
  assign take_l2        = mem_rsp_valid && (state_q == ST_WAIT_L2);
  assign lvl1_link_take = take_l1 && ent_link;
  assign walk_abort     = (take_l1 || take_l2) && (ent_absent || ent_void);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_READ_L1;
      ST_READ_L1: state_d = ST_WAIT_L1;
      ST_WAIT_L1: if (take_l1) state_d = ent_link ? ST_READ_L2 : ST_FAULT;
      ST_READ_L2: state_d = ST_WAIT_L2;
      ST_WAIT_L2: if (take_l2) state_d = ent_link ? ST_DONE : ST_FAULT;
      ST_DONE:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      vpn_q        <= '0;
      root_q       <= '0;
      table_q      <= '0;
      ppn_q        <= '0;
      perm_q       <= '0;
      flt_level_q  <= 1'b0;
      flt_absent_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        vpn_q  <= req_vpn;
        root_q <= root_base;
      end
      if (take_l1) begin
        table_q      <= ent_frame;
        flt_level_q  <= 1'b0;
        flt_absent_q <= ent_absent;
      end
      if (take_l2) begin
        ppn_q        <= ent_frame;
        perm_q       <= ent_perm;
        flt_level_q  <= 1'b1;
        flt_absent_q <= ent_absent;
      end
    end
  end

  assign mem_rd_req   = (state_q == ST_READ_L1) || (state_q == ST_READ_L2);
  assign mem_rd_addr  = (state_q == ST_READ_L2) ? lvl_addr[1] : lvl_addr[0];
  assign refill_valid = (state_q == ST_DONE);
  assign fault_valid  = (state_q == ST_FAULT);
  assign resp_vpn     = vpn_q;
  assign refill_ppn   = ppn_q;
  assign refill_perm  = perm_q;
  assign fault_level  = flt_level_q;
  assign fault_absent = flt_absent_q;

endmodule

// File: rtl/ptw_checks.sv
module ptw_checks (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_rd_req,
  input logic refill_valid,
  input logic fault_valid,
  input logic lvl1_link_take,
  input logic walk_abort
);

  a_r8_refill_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |=> !refill_valid);

  a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(refill_valid && fault_valid));

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_no_read_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_req);

  a_r2_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_req);

  a_r3_link_reads_next: assert property (@(posedge clk) disable iff (!rst_n)
    lvl1_link_take |=> mem_rd_req);

  a_r5_abort_faults: assert property (@(posedge clk) disable iff (!rst_n)
    walk_abort |=> (fault_valid && !mem_rd_req));

  a_r10_ready_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid || fault_valid) |=> req_ready);

endmodule

bind pt_walker ptw_checks u_ptw_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_rd_req    (mem_rd_req),
  .refill_valid  (refill_valid),
  .fault_valid   (fault_valid),
  .lvl1_link_take(lvl1_link_take),
  .walk_abort    (walk_abort)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT = 32'h0001_0000;

  // Sparse physical memory: any address not listed reads as zero
  localparam int NP = 9;
  localparam logic [31:0] PT_ADDR [NP] = '{
    32'h0001_0004, 32'h0001_0008, 32'h0001_000C, 32'h0001_0FFC,
    32'h0002_0014, 32'h0002_0018, 32'h0002_0020, 32'h0003_0FFC,
    32'h0005_0000};
  localparam logic [31:0] PT_DATA [NP] = '{
    32'h0002_0003, 32'h0003_0003, 32'h0004_0001, 32'h0005_0003,
    32'hABCD_E00F, 32'h1234_5001, 32'h5555_5002, 32'hFFFF_F03F,
    32'h0000_1017};

  // Vectors: kind 0 refill, 1 fault not resident, 2 fault nonexistent
  localparam int NV = 8;
  localparam logic [19:0] V_VPN  [NV] = '{20'h00405, 20'h00406, 20'h00407, 20'h00C00,
                                          20'h00000, 20'h00BFF, 20'hFFC00, 20'h00408};
  localparam int          V_LAT  [NV] = '{1, 2, 1, 3, 1, 2, 1, 2};
  localparam int          V_KIND [NV] = '{0, 1, 2, 1, 2, 0, 0, 2};
  localparam logic        V_LVL  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [19:0] V_PPN  [NV] = '{20'hABCDE, 20'h0, 20'h0, 20'h0,
                                          20'h0, 20'hFFFFF, 20'h00001, 20'h0};
  localparam logic [3:0]  V_PERM [NV] = '{4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 4'h5, 4'h0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] root_base;
  logic        req_valid;
  logic [19:0] req_vpn;
  logic        req_ready;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        refill_valid;
  logic [19:0] resp_vpn;
  logic [19:0] refill_ppn;
  logic [3:0]  refill_perm;
  logic        fault_valid;
  logic        fault_level;
  logic        fault_absent;

  int checks = 0;
  int errors = 0;
  int lat    = 1;
  int reads  = 0;
  logic [31:0] rd_log [4];

  pt_walker dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .root_base    (root_base),
    .req_valid    (req_valid),
    .req_vpn      (req_vpn),
    .req_ready    (req_ready),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .refill_valid (refill_valid),
    .resp_vpn     (resp_vpn),
    .refill_ppn   (refill_ppn),
    .refill_perm  (refill_perm),
    .fault_valid  (fault_valid),
    .fault_level  (fault_level),
    .fault_absent (fault_absent)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_lookup(input logic [31:0] a);
    for (int k = 0; k < NP; k++) if (PT_ADDR[k] == a) return PT_DATA[k];
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Memory responder, sampling at the falling edge
  initial begin
    logic [31:0] a;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_rd_req) begin
        a = mem_rd_addr;
        if (reads < 4) rd_log[reads] = a;
        reads++;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_lookup(a);
      end
    end
  end

  task automatic wait_result(input string tag);
    int n = 0;
    while (!(refill_valid || fault_valid) && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (n >= 100) chk(tag, "response timeout", 32'd1, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0]  l1, l2;
    logic [31:0] a1, a2;
    int          exp_reads;
    rst_n     = 1'b0;
    root_base = ROOT;
    req_valid = 1'b0;
    req_vpn   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "mem_rd_req", 32'(mem_rd_req), 32'd0);
    chk("R1", "refill_valid", 32'(refill_valid), 32'd0);
    chk("R1", "fault_valid", 32'(fault_valid), 32'd0);

    // Vector table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      lat   = V_LAT[i];
      reads = 0;
      l1 = V_VPN[i][19:10];
      l2 = V_VPN[i][9:0];
      a1 = ROOT + {20'h0, l1, 2'b00};
      a2 = (mem_lookup(a1) & 32'hFFFF_F000) + {20'h0, l2, 2'b00};
      req_vpn   = V_VPN[i];
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_result("R8");
      if (V_KIND[i] == 0) begin
        chk("R4", "refill_valid", 32'(refill_valid), 32'd1);
        chk("R4", "refill_ppn", 32'(refill_ppn), 32'(V_PPN[i]));
        chk("R4", "refill_perm", 32'(refill_perm), 32'(V_PERM[i]));
        chk("R4", "resp_vpn", 32'(resp_vpn), 32'(V_VPN[i]));
      end else begin
        chk(V_KIND[i] == 1 ? "R5" : "R6", "fault_valid", 32'(fault_valid), 32'd1);
        chk(V_KIND[i] == 1 ? "R5" : "R6", "fault_absent", 32'(fault_absent),
            V_KIND[i] == 1 ? 32'd1 : 32'd0);
        chk("R7", "fault_level", 32'(fault_level), 32'(V_LVL[i]));
        chk("R7", "resp_vpn", 32'(resp_vpn), 32'(V_VPN[i]));
      end
      chk("R8", "exclusive", 32'(refill_valid && fault_valid), 32'd0);
      exp_reads = (V_KIND[i] != 0 && V_LVL[i] == 1'b0) ? 1 : 2;
      chk(V_KIND[i] == 0 ? "R3" : "R6", "read count", 32'(reads), 32'(exp_reads));
      chk("R2", "first read addr", rd_log[0], a1);
      if (exp_reads == 2) chk("R3", "second read addr", rd_log[1], a2);
      @(negedge clk);
      chk("R8", "pulse ends", 32'(refill_valid || fault_valid), 32'd0);
      chk("R9", "ready again", 32'(req_ready), 32'd1);
    end

    // R2: root captured at acceptance, later change ignored
    lat = 2; reads = 0;
    req_vpn = 20'h00405; req_valid = 1'b1;
    @(posedge clk);
    #1 root_base = 32'h0;
    req_valid = 1'b0;
    @(negedge clk);
    wait_result("R2");
    chk("R2", "first read with root changed", rd_log[0], ROOT + 32'h4);
    chk("R2", "refill with root changed", 32'(refill_ppn), 32'hABCDE);
    root_base = ROOT;
    @(negedge clk);

    // R9 and R10: request held through busy and response cycles
    lat = 3; reads = 0;
    req_vpn = 20'h00405; req_valid = 1'b1;
    @(negedge clk);
    req_vpn = 20'h00BFF;
    chk("R9", "busy after accept", 32'(req_ready), 32'd0);
    wait_result("R9");
    chk("R9", "first walk result kept", 32'(refill_ppn), 32'hABCDE);
    chk("R9", "first walk vpn kept", 32'(resp_vpn), 32'h00405);
    chk("R9", "no extra read while busy", 32'(reads), 32'd2);
    chk("R10", "not ready in response cycle", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R10", "idle cycle after response", 32'(req_ready), 32'd1);
    chk("R10", "no read before accept", 32'(reads), 32'd2);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "held request taken", 32'(req_ready), 32'd0);
    wait_result("R10");
    chk("R10", "second walk ppn", 32'(refill_ppn), 32'hFFFFF);
    chk("R10", "second walk vpn", 32'(resp_vpn), 32'h00BFF);
    chk("R10", "second walk first read", rd_log[2], ROOT + 32'h8);
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule